// File: doc/BRIEF.md
# Gray Code Track Synchronizer

This block builds a monotonic 16-bit absolute Gray position word from three kinds of digitized optical signals. Eleven coarse code tracks carry the upper part of a 12-bit Gray position. A quadrature pair, sine-derived and cosine-derived and 90 degrees apart, carries the two lowest position steps precisely. A 4-bit interpolated fine field extends the word below them. The coarse comparators may flip a little before or after their true position. When correction is enabled, the block re-times every coarse transition to the precise quadrature edges, so that the 12 upper bits take their accuracy from the quadrature pair alone.

All inputs go through a two-flop synchronizer and the word is registered once per clock. The correction decodes the quadrant from the quadrature pair. It converts the coarse Gray tracks to binary and checks the lowest coarse binary bit against the quadrant. On a mismatch it moves the coarse value one step forward or back, with the direction taken from the quadrant, and then re-encodes the result as Gray. When correction is disabled, the raw tracks pass through. The fine field is never altered.

Top module: `gray_track_sync`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the clock edge after it is applied, `pos_o` is all zeros.
- R2: An input value that is present at clock edge N appears in `pos_o` after edge N+2, which is three register stages in total (two synchronizer stages and one output stage).
- R3: `pos_o[3:0]` always equals the `fine_i` value that was synchronized with the rest of the word, whatever the correction setting.
- R4: `pos_o[4]` (12-bit Gray bit 0) always equals the synchronized `quad_a_i`.
- R5: With `corr_en_i`=0, `pos_o[15:5]` equals `coarse_i` as received. `coarse_i[10]` is the most significant track.
- R6: The quadrant is decoded with binary position bit 1 = `quad_b_i` and binary bit 0 = `quad_a_i` XOR `quad_b_i`. With `corr_en_i`=1, the Gray-to-binary value of `pos_o[15:4]` has exactly these two low bits.
- R7: With `corr_en_i`=1, a coarse code that is off by one coarse step at a transition is corrected. If the quadrant is even, the coarse value was late and is raised by one. If the quadrant is odd, it was early and is lowered by one. Both cases wrap modulo 2048. `pos_o[15:4]` is then the exact 12-bit Gray position.
- R8: With `corr_en_i`=1, two consecutive words whose source positions differ by one 16-bit step differ in exactly one bit. This includes the wrap between the maximum position and zero.
- R9: R7 and R8 hold when the position moves downward as well as upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| coarse_i | input | 11 | Coarse Gray tracks, bit 10 most significant |
| quad_a_i | input | 1 | Digitized sine track (Gray bit 0 of the 12-bit code) |
| quad_b_i | input | 1 | Digitized cosine track, 90 degrees shifted |
| fine_i | input | 4 | Interpolated fine Gray bits |
| corr_en_i | input | 1 | 1 = correct coarse transitions, 0 = bypass |
| pos_o | output | 16 | Registered 16-bit Gray position |

## Verification
The hardest case to reach is a coarse track that has already flipped while the quadrature pair still reports the old quadrant, or one that has not yet flipped. These cases matter most where the coarse value wraps around zero. The stimulus sweeps the position up and down through the wrap point, one fine step per clock. For each step it draws a random early, late or exact coarse offset of one position step. The reference model checks every word against the exact Gray position and checks single-bit adjacency between consecutive words.

// File: rtl/gts_pkg.sv
package gts_pkg;

    localparam int unsigned COARSE_BITS = 11;
    localparam int unsigned FINE_BITS   = 4;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quadrant_e;

    // Binary low bits of the position from the sine/cosine pair.
    function automatic quadrant_e quad_decode(input logic sin_bit, input logic cos_bit);
        return quadrant_e'({cos_bit, cos_bit ^ sin_bit});
    endfunction

endpackage

// File: rtl/gts_sync_chain.sv
module gts_sync_chain #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int s = 0; s < STAGES; s++) begin
            if (rst_i) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gts_gray_to_bin.sv
module gts_gray_to_bin #(
    parameter int unsigned WIDTH = 11
) (
    input  logic [WIDTH-1:0] gray_i,
    output logic [WIDTH-1:0] bin_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[WIDTH-1:i];
    end

endmodule

// File: rtl/gts_bin_to_gray.sv
module gts_bin_to_gray #(
    parameter int unsigned WIDTH = 12
) (
    input  logic [WIDTH-1:0] bin_i,
    output logic [WIDTH-1:0] gray_o
);

    assign gray_o = bin_i ^ (bin_i >> 1);

endmodule

// File: rtl/gts_coarse_fix.sv
module gts_coarse_fix
    import gts_pkg::*;
#(
    parameter int unsigned COARSE_W = 11
) (
    input  logic [COARSE_W-1:0] coarse_bin_i,
    input  quadrant_e           quad_i,
    input  logic                fix_en_i,
    output logic [COARSE_W:0]   pos_bin_o
);

    logic                bit1_want;
    logic                odd_quad;
    logic                mismatch;
    logic [COARSE_W-1:0] nudged;
    logic [COARSE_W-1:0] chosen;

    always_comb begin
        bit1_want = quad_i[1];
        odd_quad  = quad_i[0];
        mismatch  = coarse_bin_i[0] != bit1_want;
        // Even quadrant: coarse transition lagging, step forward.
        // Odd quadrant: coarse transition leading, step back.
        if (odd_quad) begin
            nudged = coarse_bin_i - COARSE_W'(1);
        end else begin
            nudged = coarse_bin_i + COARSE_W'(1);
        end
        chosen    = (fix_en_i && mismatch) ? nudged : coarse_bin_i;
        pos_bin_o = {chosen, odd_quad};
    end

endmodule

// File: rtl/gray_track_sync.sv
module gray_track_sync
    import gts_pkg::*;
#(
    parameter int unsigned COARSE_W = COARSE_BITS,
    parameter int unsigned FINE_W   = FINE_BITS,
    parameter int unsigned SYNC_N   = SYNC_DEPTH
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [COARSE_W-1:0]        coarse_i,
    input  logic                       quad_a_i,
    input  logic                       quad_b_i,
    input  logic [FINE_W-1:0]          fine_i,
    input  logic                       corr_en_i,
    output logic [COARSE_W+FINE_W:0]   pos_o
);

    localparam int unsigned UPPER_W = COARSE_W + 1;
    localparam int unsigned OUT_W   = UPPER_W + FINE_W;
    localparam int unsigned IN_W    = COARSE_W + FINE_W + 3;

    typedef struct packed {
        logic [OUT_W-1:0] word;
    } state_t;

    state_t state_d, state_q;

    logic [IN_W-1:0]     raw_vec;
    logic [IN_W-1:0]     sync_vec;
    logic                en_s;
    logic [COARSE_W-1:0] coarse_s;
    logic                qb_s;
    logic                qa_s;
    logic [FINE_W-1:0]   fine_s;
    quadrant_e           quad_s;
    logic [COARSE_W-1:0] coarse_bin;
    logic [UPPER_W-1:0]  fixed_bin;
    logic [UPPER_W-1:0]  fixed_gray;

    assign raw_vec = {corr_en_i, coarse_i, quad_b_i, quad_a_i, fine_i};

    gts_sync_chain #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    assign {en_s, coarse_s, qb_s, qa_s, fine_s} = sync_vec;
    assign quad_s = quad_decode(qa_s, qb_s);

    gts_gray_to_bin #(
        .WIDTH (COARSE_W)
    ) u_g2b (
        .gray_i (coarse_s),
        .bin_o  (coarse_bin)
    );

    gts_coarse_fix #(
        .COARSE_W (COARSE_W)
    ) u_fix (
        .coarse_bin_i (coarse_bin),
        .quad_i       (quad_s),
        .fix_en_i     (en_s),
        .pos_bin_o    (fixed_bin)
    );

    gts_bin_to_gray #(
        .WIDTH (UPPER_W)
    ) u_b2g (
        .bin_i  (fixed_bin),
        .gray_o (fixed_gray)
    );

    always_comb begin
        state_d = state_q;
        if (en_s) begin
            state_d.word = {fixed_gray, fine_s};
        end else begin
            state_d.word = {coarse_s, qa_s, fine_s};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_o = state_q.word;

endmodule

// File: rtl/gray_track_sync_chk.sv
module gray_track_sync_chk #(
    parameter int unsigned COARSE_W = 11,
    parameter int unsigned FINE_W   = 4
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic [COARSE_W-1:0]      coarse_i,
    input logic                     quad_a_i,
    input logic                     quad_b_i,
    input logic [FINE_W-1:0]        fine_i,
    input logic                     corr_en_i,
    input logic [COARSE_W+FINE_W:0] pos_o
);

    localparam int unsigned UPPER_W = COARSE_W + 1;
    localparam int unsigned LAT     = 3;

    logic [1:0]         warm_cnt_q;
    logic               warm;
    logic [UPPER_W-1:0] up_bin;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm_cnt_q <= '0;
        end else if (warm_cnt_q != 2'd3) begin
            warm_cnt_q <= warm_cnt_q + 2'd1;
        end
    end

    assign warm = (warm_cnt_q == 2'd3);

    for (genvar i = 0; i < UPPER_W; i++) begin : g_bin
        assign up_bin[i] = ^pos_o[COARSE_W+FINE_W:FINE_W+i];
    end

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (pos_o == '0));

    p_fine_pass_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        warm |-> (pos_o[FINE_W-1:0] == $past(fine_i, LAT)));

    p_sine_bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        warm |-> (pos_o[FINE_W] == $past(quad_a_i, LAT)));

    p_bypass_raw_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && !$past(corr_en_i, LAT)) |->
            (pos_o[COARSE_W+FINE_W:FINE_W+1] == $past(coarse_i, LAT)));

    p_quadrant_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && $past(corr_en_i, LAT)) |->
            (up_bin[1:0] == {$past(quad_b_i, LAT), $past(quad_a_i ^ quad_b_i, LAT)}));

endmodule

bind gray_track_sync gray_track_sync_chk #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .coarse_i  (coarse_i),
    .quad_a_i  (quad_a_i),
    .quad_b_i  (quad_b_i),
    .fine_i    (fine_i),
    .corr_en_i (corr_en_i),
    .pos_o     (pos_o)
);

// File: tb/gray_track_sync_tb_top.sv
module gray_track_sync_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [10:0] coarse_i = '0;
    logic        quad_a_i = 1'b0;
    logic        quad_b_i = 1'b0;
    logic [3:0]  fine_i = '0;
    logic        corr_en_i = 1'b0;
    logic [15:0] pos_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    int          p16_q[$];
    bit          en_q[$];
    logic [3:0]  fine_q[$];

    bit          prev_ok = 0;
    int          prev_p16;
    bit          prev_en;
    logic [15:0] prev_out;

    always #2.5 clk_i = ~clk_i;

    gray_track_sync dut_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .coarse_i  (coarse_i),
        .quad_a_i  (quad_a_i),
        .quad_b_i  (quad_b_i),
        .fine_i    (fine_i),
        .corr_en_i (corr_en_i),
        .pos_o     (pos_o)
    );

    function automatic logic [15:0] to_gray(input int v);
        logic [15:0] b;
        b = v[15:0];
        return b ^ (b >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_out();
        logic [15:0] e;
        int          p;
        bit          en;
        logic [3:0]  f;
        int          diff;
        if (exp_q.size() != 3) return;
        e  = exp_q.pop_front();
        p  = p16_q.pop_front();
        en = en_q.pop_front();
        f  = fine_q.pop_front();
        check(pos_o == e, en ? "R7 corrected word" : "R5 bypass word", pos_o, e);
        check(pos_o[3:0] == f, "R3 fine field", {12'd0, pos_o[3:0]}, {12'd0, f});
        if (en && prev_ok && prev_en) begin
            diff = (p - prev_p16 + 65536) % 65536;
            if (diff == 1 || diff == 65535) begin
                check($countones(pos_o ^ prev_out) == 1, "R8 single bit step", pos_o, prev_out);
            end else if (diff == 16 || diff == 65520) begin
                check($countones(pos_o[15:4] ^ prev_out[15:4]) == 1, "R9 coarse step adjacency",
                      pos_o, prev_out);
            end
        end
        prev_ok  = 1;
        prev_p16 = p;
        prev_en  = en;
        prev_out = pos_o;
    endtask

    // One clock: check the word due now, then present a new position.
    task automatic step(input int pos16, input int delta, input bit en);
        int          pp;
        int          p;
        int          cp;
        logic [15:0] g;
        logic [10:0] cg;
        logic [15:0] e;
        @(negedge clk_i);
        compare_out();
        pp = ((pos16 % 65536) + 65536) % 65536;
        p  = pp >> 4;
        g  = to_gray(pp);
        cp = ((((p + delta) % 4096) + 4096) % 4096) >> 1;
        cg = 11'(cp ^ (cp >> 1));
        coarse_i  = cg;
        quad_a_i  = g[4];
        quad_b_i  = p[1];
        fine_i    = g[3:0];
        corr_en_i = en;
        e = en ? g : {cg, g[4], g[3:0]};
        exp_q.push_back(e);
        p16_q.push_back(pp);
        en_q.push_back(en);
        fine_q.push_back(g[3:0]);
    endtask

    task automatic sweep(input int start, input int n, input int stride, input bit en, input bit jitter);
        for (int i = 0; i < n; i++) begin
            step(start + i * stride, jitter ? int'($urandom_range(0, 2)) - 1 : 0, en);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_i = 1'b1;
        coarse_i = '0; quad_a_i = 0; quad_b_i = 0; fine_i = '0; corr_en_i = 0;
        exp_q.delete(); p16_q.delete(); en_q.delete(); fine_q.delete();
        prev_ok = 0;
        repeat (3) @(negedge clk_i);
        check(pos_o == 16'h0000, "R1 reset state", pos_o, 16'h0000);
        rst_i = 1'b0;
    endtask

    initial begin
        do_reset();

        // R2: a new value shows up after exactly three edges.
        @(negedge clk_i);
        coarse_i = 11'h5A5; quad_a_i = 1; quad_b_i = 0; fine_i = 4'h9; corr_en_i = 0;
        repeat (2) @(negedge clk_i);
        check(pos_o == 16'h0000, "R2 not yet visible", pos_o, 16'h0000);
        @(negedge clk_i);
        check(pos_o == {11'h5A5, 1'b1, 4'h9}, "R2 visible after three edges",
              pos_o, {11'h5A5, 1'b1, 4'h9});

        // R7/R8: upward through the wrap with random coarse offsets.
        sweep(65536 - 700, 1400, 1, 1, 1);
        // R9: downward through the wrap.
        sweep(700, 1400, -1, 1, 1);
        // R9: one 12-bit step per clock, both directions, through the wrap.
        sweep(4096 * 16 - 16 * 40, 300, 16, 1, 1);
        sweep(16 * 40, 300, -16, 1, 1);
        // R5: bypass, misplaced coarse edges pass through.
        sweep(30000, 500, 1, 0, 1);
        // R6/R7: random positions and offsets, correction on and off.
        for (int i = 0; i < 600; i++) begin
            step(int'($urandom_range(0, 65535)), int'($urandom_range(0, 2)) - 1, i[0]);
        end
        // R7: boundary positions with forced late and early coarse.
        step(0, -1, 1); step(1, 1, 1); step(65535, 1, 1); step(65520, -1, 1);
        step(32, -1, 1); step(48, 1, 1); step(48, -1, 1); step(32, 1, 1);
        sweep(12345, 10, 1, 1, 0);

        // R1: reset applied mid-stream.
        do_reset();
        sweep(100, 20, 1, 1, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule